// File: doc/BRIEF.md
# Write-Back Victim Buffer Controller

This block handles misses for a write-back cache that keeps a dirty flag in every line. The cache presents each miss together with the line it is evicting: the victim's line address, its four data words and its dirty flag. A clean victim is dropped. A dirty victim is parked in a two-entry writeback buffer, so the controller can send the fill read to the next memory level at once. Parked victims are written to the next level later, as whole lines, and only while no fill is in flight.

A miss whose address matches a parked victim gets its line straight from the buffer. That entry is then discarded and is never written back. Store misses allocate. The fetched line, or the parked line, has the store word merged into it before it is handed to the cache on the fill output. The lower level sees one request port with a valid/ready handshake and a one-bit type (0 = read, 1 = write), plus a response strobe that carries the returned line.

Top module: `victim_wb_ctrl`

## Requirements
- R1: A miss with a clean victim that matches no parked victim causes exactly one lower-level request: a read (`mem_req_write`=0) at the miss address. `fill_line` then equals the returned line, `fill_from_buf` is 0, and `fill_valid` is high for exactly one cycle.
- R2: For a dirty miss, the fill read is issued before any writeback of that victim. The victim is later sent as a write (`mem_req_write`=1) carrying its own address and its full four-word line. A write request is only ever made when the buffer holds an entry.
- R3: No write request is presented while a fill read is outstanding, that is, from the accepted read until the matching `fill_valid`.
- R4: The buffer holds at most 2 victims. A dirty miss that arrives with the buffer full is not accepted. The controller first drains one victim and then accepts the miss.
- R5: A miss whose address equals a parked victim's address is served from the buffer with `fill_from_buf`=1 and makes no lower-level request. That entry is discarded and is never written back.
- R6: On a store miss, the fill line is the fetched line with word `miss_word` replaced by `miss_wdata`. Word k occupies bits [32k+31:32k].
- R7: Parked victims are written back oldest first.
- R8: A lower-level request that is not yet accepted keeps `mem_req_valid`, `mem_req_write` and `mem_req_addr` unchanged until `mem_req_ready`.
- R9: During and right after reset, `mem_req_valid` and `fill_valid` are 0 and `miss_ready` is 1 (buffer empty).
- R10: A store miss that matches a parked victim returns the parked line with the store word merged in (same word positions as R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Miss request accepted this cycle when high with miss_valid |
| miss_addr | input | ADDR_W | Line address of the missing block |
| miss_store | input | 1 | Miss is a store (write-allocate merge) |
| miss_word | input | log2(LINE_WORDS) | Word index of the store |
| miss_wdata | input | WORD_W | Store data |
| victim_dirty | input | 1 | Evicted line is dirty |
| victim_addr | input | ADDR_W | Line address of the evicted line |
| victim_line | input | WORD_W*LINE_WORDS | Data of the evicted line |
| mem_req_valid | output | 1 | Lower-level request valid |
| mem_req_ready | input | 1 | Lower level takes the request |
| mem_req_write | output | 1 | 0 = fill read, 1 = victim writeback |
| mem_req_addr | output | ADDR_W | Request line address |
| mem_req_line | output | WORD_W*LINE_WORDS | Writeback data |
| mem_rsp_valid | input | 1 | Fill data returned |
| mem_rsp_line | input | WORD_W*LINE_WORDS | Returned line |
| fill_valid | output | 1 | Fill line for the cache, one-cycle pulse |
| fill_addr | output | ADDR_W | Line address of the fill |
| fill_line | output | WORD_W*LINE_WORDS | Fill data, with any store merged in |
| fill_from_buf | output | 1 | Fill was served from the victim buffer |

## Verification
Clean misses show that nothing but one read goes out. Dirty misses show the order of the read and the later writeback, and that the write carries the victim's line. A chain of three dirty misses with no idle gap, one of them with a slow response, fills the buffer. It tells a correct full-stall (drain first, then accept) apart from an overflow, and shows that no drain slips into a long fill wait. Misses to a just-parked address, both loads and stores, tell a buffer hit apart from a refetch and show that the discarded entry never reaches memory. Store misses at the first and a middle word, and a held-off request, check the merge position and request stability.

// File: rtl/vwb_pkg.sv
// Package: shared controller state encoding for the victim writeback controller.
package vwb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FILL_REQ  = 3'd1,
        ST_FILL_WAIT = 3'd2,
        ST_FILL_DONE = 3'd3,
        ST_DRAIN     = 3'd4
    } ctl_state_t;
endpackage

// File: rtl/vwb_tag_cmp.sv
// Module: vwb_tag_cmp
// Compares one buffer entry's line address with a lookup address.
// Assumes: an invalid entry never matches.
module vwb_tag_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic              ent_valid,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              match
);
    // Match only on a live entry with an equal address.
    assign match = ent_valid && (ent_addr == look_addr);
endmodule

// File: rtl/vwb_line_merge.sv
// Module: vwb_line_merge
// Replaces one word of a line with store data (write-allocate merge).
// Assumes: word k sits at bits [k*WORD_W +: WORD_W].
module vwb_line_merge #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic [WORD_W*LINE_WORDS-1:0]   base_line,
    input  logic                           wr_en,
    input  logic [$clog2(LINE_WORDS)-1:0]  wr_idx,
    input  logic [WORD_W-1:0]              wr_word,
    output logic [WORD_W*LINE_WORDS-1:0]   merged_line
);
    localparam int IDX_W = $clog2(LINE_WORDS);

    // One word slot per generate step: take store data at the selected index.
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        assign merged_line[w*WORD_W +: WORD_W] =
            (wr_en && (wr_idx == IDX_W'(w))) ? wr_word : base_line[w*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/vwb_victim_store.sv
// Module: vwb_victim_store
// Small age-ordered store of dirty victim lines. Entry 0 is the oldest.
// Valid entries stay packed at the low indices, and removing an entry
// shifts the younger ones down. A push lands in the first free slot after
// any removal in the same cycle. Lookup is fully associative.
// Assumes: the caller never pushes into a full store without a removal,
// and only removes valid entries.
module vwb_victim_store #(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 128,
    parameter int DEPTH  = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   push_en,
    input  logic [ADDR_W-1:0]                      push_addr,
    input  logic [LINE_W-1:0]                      push_line,
    input  logic                                   rm_en,
    input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rm_idx,
    input  logic [ADDR_W-1:0]                      look_addr,
    output logic                                   look_hit,
    output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] look_idx,
    output logic [LINE_W-1:0]                      look_line,
    output logic                                   head_valid,
    output logic [ADDR_W-1:0]                      head_addr,
    output logic [LINE_W-1:0]                      head_line,
    output logic                                   full,
    output logic [$clog2(DEPTH+1)-1:0]             count
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]  ent_v;
    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [LINE_W-1:0] ent_line [DEPTH];

    logic [DEPTH-1:0]  hit_vec;
    logic [DEPTH-1:0]  take_up;
    logic [DEPTH-1:0]  up_v;
    logic [ADDR_W-1:0] up_addr [DEPTH];
    logic [LINE_W-1:0] up_line [DEPTH];
    logic [CNT_W-1:0]  kept;

    // Per-entry address compare and shift-down source.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        vwb_tag_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .ent_valid (ent_v[i]),
            .ent_addr  (ent_addr[i]),
            .look_addr (look_addr),
            .match     (hit_vec[i])
        );
        assign take_up[i] = rm_en && (rm_idx <= IDX_W'(i));
        if (i + 1 < DEPTH) begin : g_up
            assign up_v[i]    = ent_v[i+1];
            assign up_addr[i] = ent_addr[i+1];
            assign up_line[i] = ent_line[i+1];
        end else begin : g_last
            assign up_v[i]    = 1'b0;
            assign up_addr[i] = ent_addr[i];
            assign up_line[i] = ent_line[i];
        end
    end

    // Occupancy and the slot a push will land in.
    always_comb begin : occupancy
        count = CNT_W'($countones(ent_v));
        kept  = count - CNT_W'(rm_en);
    end

    assign full       = ent_v[DEPTH-1];
    assign head_valid = ent_v[0];
    assign head_addr  = ent_addr[0];
    assign head_line  = ent_line[0];
    assign look_hit   = |hit_vec;

    // Encode the single matching entry into an index.
    always_comb begin : hit_encode
        look_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) look_idx = IDX_W'(i);
        end
    end

    assign look_line = ent_line[look_idx];

    // Entry update: push into the first free slot, else shift down over a removed entry.
    always_ff @(posedge clk) begin : entry_update
        if (!rst_n) begin
            ent_v <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push_en && (kept == CNT_W'(i))) begin
                    ent_v[i]    <= 1'b1;
                    ent_addr[i] <= push_addr;
                    ent_line[i] <= push_line;
                end else if (take_up[i]) begin
                    ent_v[i]    <= up_v[i];
                    ent_addr[i] <= up_addr[i];
                    ent_line[i] <= up_line[i];
                end
            end
        end
    end

    // R4: a push without a removal never arrives when the store is full.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !rm_en) |-> !full);

    // R5: a removal always targets a live entry.
    a_r5_remove_live: assert property (@(posedge clk) disable iff (!rst_n)
        rm_en |-> ent_v[rm_idx]);

    // R5: a lookup address matches at most one parked victim.
    a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R7: valid entries stay packed from entry 0 upward, which preserves age order.
    for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_pack_chk
        a_r7_entries_packed: assert property (@(posedge clk) disable iff (!rst_n)
            !ent_v[i] |-> !ent_v[i+1]);
    end
endmodule

// File: rtl/victim_wb_ctrl.sv
// Module: victim_wb_ctrl
// Miss controller for a write-back cache. It parks dirty victims in a small
// buffer, issues the fill read first, and drains parked victims as whole-line
// writes only when no fill is in flight. A miss that matches a parked victim
// is served from the buffer, and that entry is dropped. Store misses merge
// their word into the line before it is returned on the fill output.
// Assumes: the lower level answers every accepted read with exactly one
// mem_rsp_valid pulse, and never sends a response otherwise.
module victim_wb_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int VB_DEPTH   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               miss_valid,
    output logic                               miss_ready,
    input  logic [ADDR_W-1:0]                  miss_addr,
    input  logic                               miss_store,
    input  logic [$clog2(LINE_WORDS)-1:0]      miss_word,
    input  logic [WORD_W-1:0]                  miss_wdata,
    input  logic                               victim_dirty,
    input  logic [ADDR_W-1:0]                  victim_addr,
    input  logic [WORD_W*LINE_WORDS-1:0]       victim_line,
    output logic                               mem_req_valid,
    input  logic                               mem_req_ready,
    output logic                               mem_req_write,
    output logic [ADDR_W-1:0]                  mem_req_addr,
    output logic [WORD_W*LINE_WORDS-1:0]       mem_req_line,
    input  logic                               mem_rsp_valid,
    input  logic [WORD_W*LINE_WORDS-1:0]       mem_rsp_line,
    output logic                               fill_valid,
    output logic [ADDR_W-1:0]                  fill_addr,
    output logic [WORD_W*LINE_WORDS-1:0]       fill_line,
    output logic                               fill_from_buf
);
    import vwb_pkg::*;

    localparam int LINE_W = WORD_W * LINE_WORDS;
    localparam int WIDX_W = $clog2(LINE_WORDS);
    localparam int VIDX_W = (VB_DEPTH > 1) ? $clog2(VB_DEPTH) : 1;
    localparam int VCNT_W = $clog2(VB_DEPTH + 1);

    ctl_state_t        st, st_nxt;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_store;
    logic [WIDX_W-1:0] cur_word;
    logic [WORD_W-1:0] cur_wdata;
    logic [LINE_W-1:0] line_q;
    logic              from_buf_q;

    logic              accept;
    logic              vb_push;
    logic              vb_rm;
    logic [VIDX_W-1:0] vb_rm_idx;
    logic              vb_hit;
    logic [VIDX_W-1:0] vb_hit_idx;
    logic [LINE_W-1:0] vb_hit_line;
    logic              vb_head_v;
    logic [ADDR_W-1:0] vb_head_addr;
    logic [LINE_W-1:0] vb_head_line;
    logic              vb_full;
    logic [VCNT_W-1:0] vb_count;

    logic              mg_en;
    logic [WIDX_W-1:0] mg_idx;
    logic [WORD_W-1:0] mg_word;
    logic [LINE_W-1:0] mg_base;
    logic [LINE_W-1:0] mg_line;

    // Miss acceptance: only when idle, and a dirty victim needs a free slot.
    assign miss_ready = (st == ST_IDLE) && !(victim_dirty && vb_full);
    assign accept     = miss_valid && miss_ready;

    // Buffer control: park dirty victims, drop on hit, pop the head on a drain.
    assign vb_push   = accept && victim_dirty;
    assign vb_rm     = (accept && vb_hit) || ((st == ST_DRAIN) && mem_req_ready);
    assign vb_rm_idx = (st == ST_DRAIN) ? '0 : vb_hit_idx;

    vwb_victim_store #(
        .ADDR_W (ADDR_W),
        .LINE_W (LINE_W),
        .DEPTH  (VB_DEPTH)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_en    (vb_push),
        .push_addr  (victim_addr),
        .push_line  (victim_line),
        .rm_en      (vb_rm),
        .rm_idx     (vb_rm_idx),
        .look_addr  (miss_addr),
        .look_hit   (vb_hit),
        .look_idx   (vb_hit_idx),
        .look_line  (vb_hit_line),
        .head_valid (vb_head_v),
        .head_addr  (vb_head_addr),
        .head_line  (vb_head_line),
        .full       (vb_full),
        .count      (vb_count)
    );

    // Merge source: the parked line at acceptance, the returned line while waiting.
    always_comb begin : merge_select
        if (st == ST_FILL_WAIT) begin
            mg_base = mem_rsp_line;
            mg_en   = cur_store;
            mg_idx  = cur_word;
            mg_word = cur_wdata;
        end else begin
            mg_base = vb_hit_line;
            mg_en   = miss_store;
            mg_idx  = miss_word;
            mg_word = miss_wdata;
        end
    end

    vwb_line_merge #(
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_merge (
        .base_line   (mg_base),
        .wr_en       (mg_en),
        .wr_idx      (mg_idx),
        .wr_word     (mg_word),
        .merged_line (mg_line)
    );

    // Next state: a miss beats a drain; drain only when no miss can be taken.
    always_comb begin : next_state
        st_nxt = st;
        case (st)
            ST_IDLE: begin
                if (accept)         st_nxt = vb_hit ? ST_FILL_DONE : ST_FILL_REQ;
                else if (vb_head_v) st_nxt = ST_DRAIN;
            end
            ST_FILL_REQ:  if (mem_req_ready) st_nxt = ST_FILL_WAIT;
            ST_FILL_WAIT: if (mem_rsp_valid) st_nxt = ST_FILL_DONE;
            ST_FILL_DONE: st_nxt = ST_IDLE;
            ST_DRAIN:     if (mem_req_ready) st_nxt = ST_IDLE;
            default:      st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin : state_reg
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Miss context and fill line capture.
    always_ff @(posedge clk) begin : miss_context
        if (!rst_n) begin
            cur_addr   <= '0;
            cur_store  <= 1'b0;
            cur_word   <= '0;
            cur_wdata  <= '0;
            line_q     <= '0;
            from_buf_q <= 1'b0;
        end else if (accept) begin
            cur_addr   <= miss_addr;
            cur_store  <= miss_store;
            cur_word   <= miss_word;
            cur_wdata  <= miss_wdata;
            from_buf_q <= vb_hit;
            if (vb_hit) line_q <= mg_line;
        end else if ((st == ST_FILL_WAIT) && mem_rsp_valid) begin
            line_q <= mg_line;
        end
    end

    // Lower-level request: fill read or head-of-buffer writeback.
    always_comb begin : mem_request
        mem_req_valid = (st == ST_FILL_REQ) || (st == ST_DRAIN);
        mem_req_write = (st == ST_DRAIN);
        mem_req_addr  = (st == ST_DRAIN) ? vb_head_addr : cur_addr;
        mem_req_line  = vb_head_line;
    end

    // Fill output to the cache.
    assign fill_valid    = (st == ST_FILL_DONE);
    assign fill_addr     = cur_addr;
    assign fill_line     = line_q;
    assign fill_from_buf = from_buf_q;

    // Tracks, from the port handshakes alone, whether a fill read is outstanding.
    logic rd_open;
    always_ff @(posedge clk) begin : read_tracker
        if (!rst_n)                                            rd_open <= 1'b0;
        else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_open <= 1'b1;
        else if (fill_valid)                                   rd_open <= 1'b0;
    end

    // R3: no writeback is offered while a fill read is outstanding.
    a_r3_no_drain_during_fill: assert property (@(posedge clk) disable iff (!rst_n)
        rd_open |-> !(mem_req_valid && mem_req_write));

    // R2: a writeback is only offered when the buffer holds a victim.
    a_r2_drain_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (vb_count != '0));

    // R8: a pending request holds its type and address until taken.
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr)));

    // R1: the fill strobe lasts a single cycle.
    a_r1_fill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);
endmodule

// File: tb/tb_victim_wb_ctrl.sv
module tb_victim_wb_ctrl;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         miss_valid, miss_ready, miss_store, victim_dirty;
    logic [15:0]  miss_addr, victim_addr;
    logic [1:0]   miss_word;
    logic [31:0]  miss_wdata;
    logic [127:0] victim_line;
    logic         mem_req_valid, mem_req_ready, mem_req_write;
    logic [15:0]  mem_req_addr;
    logic [127:0] mem_req_line;
    logic         mem_rsp_valid;
    logic [127:0] mem_rsp_line;
    logic         fill_valid, fill_from_buf;
    logic [15:0]  fill_addr;
    logic [127:0] fill_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // lower-level model state and request log
    int           rsp_lat = 1;
    int           rsp_cnt = 0;
    logic [15:0]  rsp_addr = '0;
    bit           block_ready = 0;
    int           n_log = 0;
    logic         log_wr   [64];
    logic [15:0]  log_addr [64];
    logic [127:0] log_line [64];

    // results of the last miss
    logic [127:0] got_line;
    logic         got_buf;
    logic [15:0]  got_addr;

    always #10 clk = ~clk;  // 50 MHz

    victim_wb_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .miss_store(miss_store), .miss_word(miss_word), .miss_wdata(miss_wdata),
        .victim_dirty(victim_dirty), .victim_addr(victim_addr), .victim_line(victim_line),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_line(mem_req_line),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_line(fill_line),
        .fill_from_buf(fill_from_buf)
    );

    function automatic logic [127:0] mem_pat(input logic [15:0] a);
        logic [127:0] r;
        for (int w = 0; w < 4; w++) r[w*32 +: 32] = {a, 8'hA5, 8'(w)};
        return r;
    endfunction

    function automatic logic [127:0] vic_pat(input logic [15:0] a);
        logic [127:0] r;
        for (int w = 0; w < 4; w++) r[w*32 +: 32] = {a, 8'h5A, 8'(w)};
        return r;
    endfunction

    function automatic logic [127:0] put_word(input logic [127:0] l, input int w, input logic [31:0] d);
        logic [127:0] r;
        r = l;
        r[w*32 +: 32] = d;
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // lower-level responder: logs accepted requests, answers reads after rsp_lat cycles
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_line  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_line  = mem_pat(rsp_addr);
                end
            end
            mem_req_ready = !block_ready;
            if (mem_req_valid && mem_req_ready && n_log < 64) begin
                log_wr[n_log]   = mem_req_write;
                log_addr[n_log] = mem_req_addr;
                log_line[n_log] = mem_req_line;
                n_log++;
                if (!mem_req_write) begin
                    rsp_cnt  = rsp_lat;
                    rsp_addr = mem_req_addr;
                end
            end
        end
    end

    task automatic idle(input int n);
        miss_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_miss(input logic [15:0] a, input bit st, input logic [1:0] w,
                           input logic [31:0] wd, input bit dirty, input logic [15:0] va);
        int guard;
        miss_valid = 1'b1; miss_addr = a; miss_store = st; miss_word = w; miss_wdata = wd;
        victim_dirty = dirty; victim_addr = va; victim_line = vic_pat(va);
        #1;
        guard = 0;
        while (!miss_ready && guard < 200) begin @(negedge clk); #1; guard++; end
        @(negedge clk);
        miss_valid = 1'b0; victim_dirty = 1'b0; miss_store = 1'b0;
        guard = 0;
        while (!fill_valid && guard < 200) begin @(negedge clk); guard++; end
        got_line = fill_line; got_buf = fill_from_buf; got_addr = fill_addr;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; miss_valid = 1'b0; miss_store = 1'b0; victim_dirty = 1'b0;
        miss_addr = '0; miss_word = '0; miss_wdata = '0; victim_addr = '0; victim_line = '0;
        repeat (3) @(negedge clk);
        check("R9 req valid in reset", 128'(mem_req_valid), 128'(0));
        check("R9 fill valid in reset", 128'(fill_valid), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 miss_ready after reset", 128'(miss_ready), 128'(1));
        check("R9 req valid after reset", 128'(mem_req_valid), 128'(0));
    endtask

    task automatic t_clean_miss;
        int base;
        base = n_log;
        do_miss(16'h0100, 0, 2'd0, 32'h0, 0, 16'h0900);
        check("R1 one request", 128'(n_log - base), 128'(1));
        check("R1 request is read", 128'(log_wr[base]), 128'(0));
        check("R1 read address", 128'(log_addr[base]), 128'(16'h0100));
        check("R1 fill data", got_line, mem_pat(16'h0100));
        check("R1 fill not from buffer", 128'(got_buf), 128'(0));
        check("R1 fill address", 128'(got_addr), 128'(16'h0100));
        idle(6);
        check("R1 nothing more after clean miss", 128'(n_log - base), 128'(1));
    endtask

    task automatic t_dirty_miss;
        int base;
        base = n_log;
        do_miss(16'h0200, 0, 2'd0, 32'h0, 1, 16'h0300);
        check("R2 fill read first", 128'(log_wr[base]), 128'(0));
        check("R2 fill data", got_line, mem_pat(16'h0200));
        idle(6);
        check("R2 two transactions", 128'(n_log - base), 128'(2));
        check("R2 writeback type", 128'(log_wr[base+1]), 128'(1));
        check("R2 writeback address", 128'(log_addr[base+1]), 128'(16'h0300));
        check("R2 writeback line", log_line[base+1], vic_pat(16'h0300));
    endtask

    task automatic t_full_chain;
        int base;
        base = n_log;
        do_miss(16'h1000, 0, 2'd0, 32'h0, 1, 16'h2000);
        rsp_lat = 6;
        do_miss(16'h1010, 0, 2'd0, 32'h0, 1, 16'h2010);
        rsp_lat = 1;
        check("R3 no drain during slow fill", 128'(n_log - base), 128'(2));
        check("R3 slow fill data", got_line, mem_pat(16'h1010));
        do_miss(16'h1020, 0, 2'd0, 32'h0, 1, 16'h2020);
        check("R4 drain before third miss", 128'(log_wr[base+2]), 128'(1));
        check("R4 R7 oldest drained first", 128'(log_addr[base+2]), 128'(16'h2000));
        check("R4 third fill read after drain", 128'({log_wr[base+3], log_addr[base+3]}),
              128'({1'b0, 16'h1020}));
        check("R4 third fill data", got_line, mem_pat(16'h1020));
        idle(10);
        check("R7 total transactions", 128'(n_log - base), 128'(6));
        check("R7 second drain", 128'({log_wr[base+4], log_addr[base+4]}), 128'({1'b1, 16'h2010}));
        check("R7 third drain", 128'({log_wr[base+5], log_addr[base+5]}), 128'({1'b1, 16'h2020}));
        check("R7 third drain line", log_line[base+5], vic_pat(16'h2020));
    endtask

    task automatic t_buf_hit;
        int base;
        base = n_log;
        do_miss(16'h3000, 0, 2'd0, 32'h0, 1, 16'h3100);
        do_miss(16'h3100, 0, 2'd0, 32'h0, 0, 16'h3900);
        check("R5 served from buffer", 128'(got_buf), 128'(1));
        check("R5 buffer line", got_line, vic_pat(16'h3100));
        check("R5 no request for hit", 128'(n_log - base), 128'(1));
        idle(8);
        check("R5 hit entry never written back", 128'(n_log - base), 128'(1));
    endtask

    task automatic t_store_hit_buf;
        int base;
        base = n_log;
        do_miss(16'h3200, 0, 2'd0, 32'h0, 1, 16'h3300);
        do_miss(16'h3300, 1, 2'd3, 32'hCAFE_F00D, 0, 16'h3900);
        check("R10 merged parked line", got_line, put_word(vic_pat(16'h3300), 3, 32'hCAFE_F00D));
        check("R10 from buffer", 128'(got_buf), 128'(1));
        idle(8);
        check("R10 no writeback of merged hit", 128'(n_log - base), 128'(1));
    endtask

    task automatic t_store_miss;
        do_miss(16'h4000, 1, 2'd0, 32'hDEAD_BEEF, 0, 16'h0);
        check("R6 store word 0", got_line, put_word(mem_pat(16'h4000), 0, 32'hDEAD_BEEF));
        do_miss(16'h4010, 1, 2'd2, 32'h1234_5678, 0, 16'h0);
        check("R6 store word 2", got_line, put_word(mem_pat(16'h4010), 2, 32'h1234_5678));
        idle(4);
    endtask

    task automatic t_backpressure;
        int base;
        int guard;
        base = n_log;
        block_ready = 1;
        miss_valid = 1'b1; miss_addr = 16'h5000; miss_store = 1'b0; victim_dirty = 1'b0;
        #1;
        guard = 0;
        while (!miss_ready && guard < 50) begin @(negedge clk); #1; guard++; end
        @(negedge clk);
        miss_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 request held", 128'({mem_req_valid, mem_req_write, mem_req_addr}),
                  128'({1'b1, 1'b0, 16'h5000}));
        end
        block_ready = 0;
        guard = 0;
        while (!fill_valid && guard < 50) begin @(negedge clk); guard++; end
        check("R8 single read after hold", 128'(n_log - base), 128'(1));
        check("R8 fill data after hold", fill_line, mem_pat(16'h5000));
        idle(4);
    endtask

    initial begin
        t_reset();
        t_clean_miss();
        t_dirty_miss();
        t_full_chain();
        t_buf_hit();
        t_store_hit_buf();
        t_store_miss();
        t_backpressure();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule